// File: doc/BRIEF.md
# Latched-Address Inverting Line Decoder

This block turns a 3-bit address into eight active-low select lines, at most one of them low at a time. A level-sensitive address latch sits in front of the decoder. While the hold input is low, the latch is transparent and the block acts as a live decoder. When hold goes high, the latch keeps the address that was present just before that edge. After that, address activity has no effect until hold returns low.

Two enables of opposite polarity sit after the decoder and gate all eight lines. One enable is active low and the other active high. The lines can only drive a select when both enables are active. Otherwise every line is high, whatever the address or the latch is doing. The enables never touch the stored address.

The latch is written as a two-state mode. `LAT_PASS` is selected while hold is low, and `LAT_HOLD` is selected while hold is high. A rising hold moves the latch from `LAT_PASS` to `LAT_HOLD`, which freezes the address. A falling hold moves it from `LAT_HOLD` to `LAT_PASS`, which reopens it. The output gate has two named conditions: `GATE_OPEN` when both enables are active, and `GATE_SHUT` for every other enable combination. The block has no clock and no reset.

Top module: `latched_line_decoder`

## Requirements
- R1: While hold_i is low, the latch is transparent. With the gate open, sel_n_o follows the current addr_i.
- R2: On a rising edge of hold_i, the value of addr_i present just before that edge is kept.
- R3: While hold_i stays high, changes on addr_i do not change sel_n_o.
- R4: With the gate open, exactly one bit of sel_n_o is 0. Its index equals the held address, where addr_i bit 0 is the least significant bit. Address 0 drives bit 0 low and address 7 drives bit 7 low.
- R5: sel_n_o is all ones unless en_n_i is 0 and en_i is 1. This holds for the three other enable combinations 00, 10 and 11, written as {en_n_i,en_i}.
- R6: Toggling the enables while hold_i is high leaves the stored address unchanged. When the gate reopens, the originally captured line is selected again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 3 | Address to decode; bit 0 is the LSB |
| hold_i | input | 1 | Latch control: low = transparent, high = hold |
| en_n_i | input | 1 | Active-low output enable |
| en_i | input | 1 | Active-high output enable |
| sel_n_o | output | 8 | Active-low one-hot select lines |

## Verification
Two events can coincide: the latch freezing its address and the address itself moving. The most sensitive case is an address change that follows a rising hold within the same clock period. The bench raises hold, then moves the address a few nanoseconds later. It passes only if the line captured before the edge stays selected. The enables are also toggled through all four combinations while the latch is holding, and the bench checks that reopening the gate selects the original line.

// File: rtl/latched_line_decoder_pkg.sv
package latched_line_decoder_pkg;

    typedef enum logic {
        LAT_PASS = 1'b0,
        LAT_HOLD = 1'b1
    } lat_mode_e;

    typedef enum logic [1:0] {
        GATE_SHUT = 2'b00,
        GATE_OPEN = 2'b01
    } gate_state_e;

endpackage

// File: rtl/lld_addr_latch.sv
module lld_addr_latch
    import latched_line_decoder_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              hold_i,
    output logic [ADDR_W-1:0] addr_q_o
);

    lat_mode_e mode;

    always_comb begin
        mode = hold_i ? LAT_HOLD : LAT_PASS;
    end

    always_latch begin
        if (mode == LAT_PASS) begin
            addr_q_o <= addr_i;
        end
    end

endmodule

// File: rtl/lld_onehot_dec.sv
module lld_onehot_dec #(
    parameter int ADDR_W = 3,
    parameter int OUT_N  = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [OUT_N-1:0]  hit_o
);

    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign hit_o[i] = (addr_i == ADDR_W'(i));
    end

endmodule

// File: rtl/lld_out_gate.sv
module lld_out_gate
    import latched_line_decoder_pkg::*;
#(
    parameter int OUT_N = 8
) (
    input  logic [OUT_N-1:0] hit_i,
    input  logic             en_n_i,
    input  logic             en_i,
    output logic [OUT_N-1:0] sel_n_o
);

    gate_state_e gstate;

    always_comb begin
        unique case ({en_n_i, en_i})
            2'b01:   gstate = GATE_OPEN;
            default: gstate = GATE_SHUT;
        endcase
    end

    always_comb begin
        unique case (gstate)
            GATE_OPEN: sel_n_o = ~hit_i;
            default:   sel_n_o = '1;
        endcase
    end

endmodule

// File: rtl/latched_line_decoder.sv
module latched_line_decoder #(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   hold_i,
    input  logic                   en_n_i,
    input  logic                   en_i,
    output logic [(1<<ADDR_W)-1:0] sel_n_o
);

    localparam int OUT_N = 1 << ADDR_W;

    logic [ADDR_W-1:0] addr_q;
    logic [OUT_N-1:0]  hit;

    lld_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
        .addr_i   (addr_i),
        .hold_i   (hold_i),
        .addr_q_o (addr_q)
    );

    lld_onehot_dec #(.ADDR_W(ADDR_W), .OUT_N(OUT_N)) u_dec (
        .addr_i (addr_q),
        .hit_o  (hit)
    );

    lld_out_gate #(.OUT_N(OUT_N)) u_gate (
        .hit_i   (hit),
        .en_n_i  (en_n_i),
        .en_i    (en_i),
        .sel_n_o (sel_n_o)
    );

    // R4: never more than one line low, whatever the inputs
    always_comb begin
        a_r4_at_most_one: assert ($countones(~sel_n_o) <= 1)
            else $error("a_r4_at_most_one");
    end

    // R4: with the gate open exactly one line is low
    always_comb begin
        if (!en_n_i && en_i) begin
            a_r4_exactly_one: assert ($countones(~sel_n_o) == 1)
                else $error("a_r4_exactly_one");
        end
    end

    // R4: the low line is the one indexed by the held address
    always_comb begin
        if (!en_n_i && en_i) begin
            a_r4_index_match: assert (sel_n_o[addr_q] == 1'b0)
                else $error("a_r4_index_match");
        end
    end

    // R5: a closed gate leaves every line high
    always_comb begin
        if (en_n_i || !en_i) begin
            a_r5_gate_shut: assert (&sel_n_o)
                else $error("a_r5_gate_shut");
        end
    end

endmodule

// File: tb/latched_line_decoder_tb.sv
module latched_line_decoder_tb;

    localparam int ADDR_W = 3;
    localparam int OUT_N  = 1 << ADDR_W;
    localparam int NVEC   = 19;

    // stimulus: {addr[2:0], hold, en_n, en, req[2:0]}
    localparam logic [8:0] VEC [NVEC] = '{
        {3'd0, 1'b0, 1'b0, 1'b1, 3'd4},
        {3'd1, 1'b0, 1'b0, 1'b1, 3'd1},
        {3'd2, 1'b0, 1'b0, 1'b1, 3'd1},
        {3'd3, 1'b0, 1'b0, 1'b1, 3'd1},
        {3'd4, 1'b0, 1'b0, 1'b1, 3'd1},
        {3'd5, 1'b0, 1'b0, 1'b1, 3'd1},
        {3'd6, 1'b0, 1'b0, 1'b1, 3'd1},
        {3'd7, 1'b0, 1'b0, 1'b1, 3'd4},
        {3'd5, 1'b0, 1'b0, 1'b1, 3'd1},
        {3'd5, 1'b1, 1'b0, 1'b1, 3'd2},
        {3'd2, 1'b1, 1'b0, 1'b1, 3'd3},
        {3'd7, 1'b1, 1'b0, 1'b1, 3'd3},
        {3'd7, 1'b1, 1'b1, 1'b1, 3'd5},
        {3'd0, 1'b1, 1'b0, 1'b0, 3'd5},
        {3'd0, 1'b1, 1'b1, 1'b0, 3'd5},
        {3'd3, 1'b1, 1'b0, 1'b1, 3'd6},
        {3'd3, 1'b0, 1'b0, 1'b1, 3'd1},
        {3'd6, 1'b0, 1'b1, 1'b0, 3'd5},
        {3'd6, 1'b0, 1'b0, 1'b1, 3'd1}
    };

    logic              clk = 1'b0;
    logic [ADDR_W-1:0] addr;
    logic              hold;
    logic              en_n;
    logic              en;
    logic [OUT_N-1:0]  sel_n;

    int n_checks = 0;
    int n_fail   = 0;
    logic [ADDR_W-1:0] ref_q = '0;

    always #5 clk = ~clk;

    latched_line_decoder #(.ADDR_W(ADDR_W)) u_dut (
        .addr_i  (addr),
        .hold_i  (hold),
        .en_n_i  (en_n),
        .en_i    (en),
        .sel_n_o (sel_n)
    );

    function automatic string req_name(input logic [2:0] r);
        case (r)
            3'd1:    return "R1";
            3'd2:    return "R2";
            3'd3:    return "R3";
            3'd4:    return "R4";
            3'd5:    return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [OUT_N-1:0] model_out(input logic [ADDR_W-1:0] q,
                                                   input logic n, input logic p);
        logic [OUT_N-1:0] v;
        v = '1;
        if (!n && p) v[q] = 1'b0;
        return v;
    endfunction

    task automatic check(input string tag);
        logic [OUT_N-1:0] exp;
        exp = model_out(ref_q, en_n, en);
        n_checks++;
        if (sel_n !== exp) begin
            n_fail++;
            $display("FAIL %s: sel_n=%b expected %b", tag, sel_n, exp);
        end
    endtask

    task automatic apply(input logic [ADDR_W-1:0] a, input logic h,
                         input logic n, input logic p, input string tag);
        @(posedge clk);
        #1;
        addr = a; hold = h; en_n = n; en = p;
        if (!h) ref_q = a;
        @(negedge clk);
        check(tag);
    endtask

    initial begin
        // watchdog
        #2000000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        // reset-like start: gate shut, latch transparent
        addr = '0; hold = 1'b0; en_n = 1'b1; en = 1'b0;
        ref_q = '0;
        @(negedge clk);
        check("R5 start");

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][8:6], VEC[i][5], VEC[i][4], VEC[i][3],
                  req_name(VEC[i][2:0]));
        end

        // R2: address moves shortly after the hold edge, same period
        apply(3'd4, 1'b0, 1'b0, 1'b1, "R1 pre-edge");
        @(posedge clk);
        #1 hold = 1'b1;
        #2 addr = 3'd1;
        @(negedge clk);
        check("R2 capture before edge");

        // R3: sweep every address while held
        for (int a = 0; a < OUT_N; a++) begin
            apply(ADDR_W'(a), 1'b1, 1'b0, 1'b1, "R3 sweep while held");
        end

        // R6: all four enable combinations while held, then reopen
        apply(3'd2, 1'b1, 1'b0, 1'b0, "R6 en 00");
        apply(3'd3, 1'b1, 1'b1, 1'b1, "R6 en 11");
        apply(3'd6, 1'b1, 1'b1, 1'b0, "R6 en 10");
        apply(3'd0, 1'b1, 1'b0, 1'b1, "R6 en 01 reopen");

        // R1: released with gate shut, then opened follows live address
        apply(3'd7, 1'b0, 1'b1, 1'b0, "R1 release shut");
        apply(3'd7, 1'b0, 1'b0, 1'b1, "R1 open at 7");
        apply(3'd0, 1'b0, 1'b0, 1'b1, "R4 line 0");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule